// File: doc/BRIEF.md
# Edge Arrival Stamper With Loss Accounting

The block watches one already-synchronised event line and gives every rising edge it accepts a time-of-arrival word. The upper field of that word is a free-running count of clock ticks. The lower field is a fine remainder code that an external interpolator presents on a port in the same cycle. Accepted words go into a small burst buffer. A consumer drains the buffer through a valid/ready pair.

After each accepted edge, a programmable holdoff keeps the capture logic from re-arming. Any edge that arrives during the holdoff is counted, never ignored without trace. A buffer that is already full causes the new word to be thrown away, and that loss is counted too.

Time is cut into measurement windows of a programmable number of ticks. At the end of each window the block publishes, in one step, the following values for that window:
- how many words were stored;
- how many were dropped;
- how many separate overflow episodes happened;
- how many edges the holdoff rejected;
- the highest buffer level reached;
- a trust bit.

The trust bit is set only when nothing overflowed and the reference-lock input stayed high for the whole window.

The capture controller is a two-state machine:
- **CAP_ARMED**: the capture logic waits for an edge.
- **CAP_HOLDOFF**: the capture logic is blind.

Its transitions are:
- **ARM_TO_HOLD**: taken on an accepted edge when the holdoff setting is nonzero.
- **HOLD_TO_ARM**: taken in the last holdoff tick.

An accepted edge with a holdoff of zero keeps the machine in CAP_ARMED. The window logic is a tick counter that wraps and publishes a snapshot at its last count.

Top module: `toa_stamp_engine`

## Requirements
- R1: A stamp word holds the tick count in bits [COARSE_W+FINE_W-1:FINE_W] and fine_code in bits [FINE_W-1:0]. Both are taken in the cycle in which ev_in is seen high after being low in the previous cycle. The tick count is 0 in the first cycle after reset, rises by one each cycle and wraps. A level that is already high as reset releases is not an edge.
- R2: While reset is applied and just after it, stamp_valid, win_done, every window count, win_highwater and win_data_valid are all 0.
- R3: An edge accepted in cycle t with holdoff_ticks = H makes edges first seen in cycles t+1 to t+H unaccepted, and each one adds 1 to win_missed. H = 0 means no blind time. The holdoff follows both stored and dropped edges.
- R4: Stored words leave in arrival order. stamp_valid is high exactly while the buffer (DEPTH entries) is not empty. A word is removed in a cycle where stamp_valid and stamp_ready are both high.
- R5: An edge accepted while the buffer held DEPTH words at the start of that cycle is discarded, even if a word is popped in the same cycle. Each discard adds 1 to win_dropped.
- R6: win_overflow_cnt counts overflow episodes. A discard adds 1 to it unless the previous accepted edge in the same window was also discarded.
- R7: A window lasts window_ticks cycles (window_ticks must be nonzero). The first window starts in the first cycle after reset. win_done is high for one cycle right after the window's last cycle. The counts then cover exactly that window's cycles, and the next window starts from zero.
- R8: While stamp_valid is high and stamp_ready is low, stamp_valid stays high and stamp_data does not change.
- R9: win_highwater is the largest buffer level at the end of any cycle of the window, counting the level carried in from the previous window.
- R10: win_data_valid is 1 only if the window had no discard and ref_locked was high in every one of its cycles.
- R11: win_captured is the number of words stored into the buffer during the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_in | input | 1 | Synchronised event line |
| fine_code | input | FINE_W | Sub-tick remainder for the current cycle |
| ref_locked | input | 1 | Reference lock status |
| holdoff_ticks | input | HOLD_W | Blind cycles after each accepted edge |
| window_ticks | input | WIN_W | Window length in cycles |
| stamp_valid | output | 1 | Buffer head holds a word |
| stamp_ready | input | 1 | Consumer takes the head word |
| stamp_data | output | COARSE_W+FINE_W | Head stamp word |
| win_done | output | 1 | One-cycle pulse: new window report |
| win_captured | output | CNT_W | Words stored in the window |
| win_dropped | output | CNT_W | Words discarded in the window |
| win_missed | output | CNT_W | Edges rejected by holdoff |
| win_overflow_cnt | output | CNT_W | Overflow episodes in the window |
| win_highwater | output | $clog2(DEPTH+1) | Peak buffer level in the window |
| win_data_valid | output | 1 | Window trusted |

## Verification
Sparse edges with a free-flowing consumer show that the stamp fields and their order are right. Edges spaced closer than the holdoff separate edges that are rejected from edges that are accepted. A stalled consumer under dense edges fills the buffer, and this pattern tells single overflow episodes apart from repeated discards; it also checks that the head word holds steady. A one-cycle lock dropout confirms that a window with no loss can still be marked untrusted. Random traffic, with changing holdoff, stall bursts and rare lock loss, compares every cycle against a model built from the requirements.

// File: rtl/toa_pkg.sv
package toa_pkg;
    typedef enum logic [0:0] {
        CAP_ARMED   = 1'b0,
        CAP_HOLDOFF = 1'b1
    } cap_state_e;
endpackage

// File: rtl/toa_capture_fsm.sv
module toa_capture_fsm
    import toa_pkg::*;
#(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_in,
    input  logic [HOLD_W-1:0] holdoff_ticks,
    output logic              cap_fire,
    output logic              miss_fire
);
    cap_state_e        state, state_n;
    logic [HOLD_W-1:0] hold_cnt, hold_cnt_n;
    logic              ev_q;
    logic              rise;

    assign rise = ev_in & ~ev_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= CAP_ARMED;
            hold_cnt <= '0;
            ev_q     <= 1'b1;
        end else begin
            state    <= state_n;
            hold_cnt <= hold_cnt_n;
            ev_q     <= ev_in;
        end
    end

    // transitions
    always_comb begin
        state_n    = state;
        hold_cnt_n = hold_cnt;
        unique case (state)
            CAP_ARMED: begin
                if (rise && holdoff_ticks != '0) begin
                    state_n    = CAP_HOLDOFF;          // ARM_TO_HOLD
                    hold_cnt_n = holdoff_ticks;
                end
            end
            CAP_HOLDOFF: begin
                hold_cnt_n = hold_cnt - HOLD_W'(1);
                if (hold_cnt == HOLD_W'(1)) state_n = CAP_ARMED;  // HOLD_TO_ARM
            end
        endcase
    end

    // outputs
    always_comb begin
        cap_fire  = 1'b0;
        miss_fire = 1'b0;
        unique case (state)
            CAP_ARMED:   cap_fire  = rise;
            CAP_HOLDOFF: miss_fire = rise;
        endcase
    end
endmodule

// File: rtl/toa_stamp_fifo.sv
module toa_stamp_fifo #(
    parameter int WIDTH = 22,
    parameter int DEPTH = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic [LVL_W-1:0] level_next
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [LVL_W-1:0] level;
    logic             push_ok, pop_ok;

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push & ~full;
    assign pop_ok  = pop & ~empty;
    assign head    = mem[rd_ptr];
    assign level_next = level + LVL_W'(push_ok) - LVL_W'(pop_ok);

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            level <= level_next;
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end
endmodule

// File: rtl/toa_window_stats.sv
module toa_window_stats #(
    parameter int WIN_W = 16,
    parameter int CNT_W = 16,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIN_W-1:0] window_ticks,
    input  logic             cap_fire,
    input  logic             miss_fire,
    input  logic             buf_full,
    input  logic [LVL_W-1:0] level_next,
    input  logic             ref_locked,
    output logic             win_done,
    output logic [CNT_W-1:0] win_captured,
    output logic [CNT_W-1:0] win_dropped,
    output logic [CNT_W-1:0] win_missed,
    output logic [CNT_W-1:0] win_overflow_cnt,
    output logic [LVL_W-1:0] win_highwater,
    output logic             win_data_valid
);
    logic [WIN_W-1:0] win_cnt;
    logic [CNT_W-1:0] cap_acc, drop_acc, miss_acc, ovf_acc;
    logic [CNT_W-1:0] cap_n, drop_n, miss_n, ovf_n;
    logic [LVL_W-1:0] hw_acc, hw_n;
    logic             lock_ok, lock_n, last_drop;
    logic             drop, store, win_last;

    assign drop     = cap_fire & buf_full;
    assign store    = cap_fire & ~buf_full;
    assign win_last = (win_cnt == window_ticks - WIN_W'(1));

    always_comb begin
        cap_n  = cap_acc  + CNT_W'(store);
        drop_n = drop_acc + CNT_W'(drop);
        miss_n = miss_acc + CNT_W'(miss_fire);
        ovf_n  = ovf_acc  + CNT_W'(drop & ~last_drop);
        hw_n   = (level_next > hw_acc) ? level_next : hw_acc;
        lock_n = lock_ok & ref_locked;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt          <= '0;
            cap_acc          <= '0;
            drop_acc         <= '0;
            miss_acc         <= '0;
            ovf_acc          <= '0;
            hw_acc           <= '0;
            lock_ok          <= 1'b1;
            last_drop        <= 1'b0;
            win_done         <= 1'b0;
            win_captured     <= '0;
            win_dropped      <= '0;
            win_missed       <= '0;
            win_overflow_cnt <= '0;
            win_highwater    <= '0;
            win_data_valid   <= 1'b0;
        end else if (win_last) begin
            win_done         <= 1'b1;
            win_captured     <= cap_n;
            win_dropped      <= drop_n;
            win_missed       <= miss_n;
            win_overflow_cnt <= ovf_n;
            win_highwater    <= hw_n;
            win_data_valid   <= lock_n & (ovf_n == '0);
            win_cnt          <= '0;
            cap_acc          <= '0;
            drop_acc         <= '0;
            miss_acc         <= '0;
            ovf_acc          <= '0;
            hw_acc           <= level_next;
            lock_ok          <= 1'b1;
            last_drop        <= 1'b0;
        end else begin
            win_done  <= 1'b0;
            win_cnt   <= win_cnt + WIN_W'(1);
            cap_acc   <= cap_n;
            drop_acc  <= drop_n;
            miss_acc  <= miss_n;
            ovf_acc   <= ovf_n;
            hw_acc    <= hw_n;
            lock_ok   <= lock_n;
            if (drop)       last_drop <= 1'b1;
            else if (store) last_drop <= 1'b0;
        end
    end
endmodule

// File: rtl/toa_stamp_engine.sv
module toa_stamp_engine #(
    parameter int COARSE_W = 16,
    parameter int FINE_W   = 6,
    parameter int DEPTH    = 8,
    parameter int HOLD_W   = 8,
    parameter int WIN_W    = 16,
    parameter int CNT_W    = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ev_in,
    input  logic [FINE_W-1:0]            fine_code,
    input  logic                         ref_locked,
    input  logic [HOLD_W-1:0]            holdoff_ticks,
    input  logic [WIN_W-1:0]             window_ticks,
    output logic                         stamp_valid,
    input  logic                         stamp_ready,
    output logic [COARSE_W+FINE_W-1:0]   stamp_data,
    output logic                         win_done,
    output logic [CNT_W-1:0]             win_captured,
    output logic [CNT_W-1:0]             win_dropped,
    output logic [CNT_W-1:0]             win_missed,
    output logic [CNT_W-1:0]             win_overflow_cnt,
    output logic [$clog2(DEPTH+1)-1:0]   win_highwater,
    output logic                         win_data_valid
);
    localparam int STAMP_W = COARSE_W + FINE_W;
    localparam int LVL_W   = $clog2(DEPTH + 1);

    logic [COARSE_W-1:0] tick;
    logic                cap_fire, miss_fire, buf_empty, buf_full;
    logic [LVL_W-1:0]    level_next;

    always_ff @(posedge clk) begin
        if (!rst_n) tick <= '0;
        else        tick <= tick + COARSE_W'(1);
    end

    toa_capture_fsm #(.HOLD_W(HOLD_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .ev_in(ev_in),
        .holdoff_ticks(holdoff_ticks),
        .cap_fire(cap_fire), .miss_fire(miss_fire)
    );

    toa_stamp_fifo #(.WIDTH(STAMP_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(cap_fire), .push_data({tick, fine_code}),
        .pop(stamp_ready), .head(stamp_data),
        .empty(buf_empty), .full(buf_full), .level_next(level_next)
    );

    assign stamp_valid = ~buf_empty;

    toa_window_stats #(.WIN_W(WIN_W), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_win (
        .clk(clk), .rst_n(rst_n), .window_ticks(window_ticks),
        .cap_fire(cap_fire), .miss_fire(miss_fire), .buf_full(buf_full),
        .level_next(level_next), .ref_locked(ref_locked),
        .win_done(win_done), .win_captured(win_captured),
        .win_dropped(win_dropped), .win_missed(win_missed),
        .win_overflow_cnt(win_overflow_cnt), .win_highwater(win_highwater),
        .win_data_valid(win_data_valid)
    );
endmodule

// File: rtl/toa_engine_checks.sv
module toa_engine_checks #(
    parameter int STAMP_W = 22,
    parameter int CNT_W   = 16,
    parameter int LVL_W   = 4,
    parameter int DEPTH   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               stamp_valid,
    input logic               stamp_ready,
    input logic [STAMP_W-1:0] stamp_data,
    input logic               win_done,
    input logic [CNT_W-1:0]   win_dropped,
    input logic [CNT_W-1:0]   win_overflow_cnt,
    input logic [LVL_W-1:0]   win_highwater,
    input logic               win_data_valid
);
    assert_valid_persist_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_valid && !stamp_ready |=> stamp_valid);

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_valid && !stamp_ready |=> $stable(stamp_data));

    assert_ovf_le_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> win_overflow_cnt <= win_dropped);

    assert_no_ovf_without_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        win_done && win_dropped == '0 |-> win_overflow_cnt == '0);

    assert_invalid_on_ovf_R10: assert property (@(posedge clk) disable iff (!rst_n)
        win_done && win_dropped != '0 |-> !win_data_valid);

    assert_hw_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> win_highwater <= LVL_W'(DEPTH));
endmodule

bind toa_stamp_engine toa_engine_checks #(
    .STAMP_W(STAMP_W), .CNT_W(CNT_W), .LVL_W(LVL_W), .DEPTH(DEPTH)
) u_chk (.*);

// File: tb/toa_stamp_engine_test.sv
module toa_stamp_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int COARSE_W = 16, FINE_W = 6, DEPTH = 8, HOLD_W = 8, WIN_W = 16, CNT_W = 16;
    localparam int STAMP_W = COARSE_W + FINE_W;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int WIN_LEN = 37;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ev_in = 1'b0, ref_locked = 1'b1, stamp_ready = 1'b0;
    logic [FINE_W-1:0] fine_code = '0;
    logic [HOLD_W-1:0] holdoff_ticks = '0;
    logic [WIN_W-1:0] window_ticks = WIN_W'(WIN_LEN);
    logic stamp_valid, win_done, win_data_valid;
    logic [STAMP_W-1:0] stamp_data;
    logic [CNT_W-1:0] win_captured, win_dropped, win_missed, win_overflow_cnt;
    logic [LVL_W-1:0] win_highwater;

    int errors = 0, checks = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    toa_stamp_engine #(.COARSE_W(COARSE_W), .FINE_W(FINE_W), .DEPTH(DEPTH),
        .HOLD_W(HOLD_W), .WIN_W(WIN_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .fine_code(fine_code),
        .ref_locked(ref_locked), .holdoff_ticks(holdoff_ticks),
        .window_ticks(window_ticks), .stamp_valid(stamp_valid),
        .stamp_ready(stamp_ready), .stamp_data(stamp_data), .win_done(win_done),
        .win_captured(win_captured), .win_dropped(win_dropped),
        .win_missed(win_missed), .win_overflow_cnt(win_overflow_cnt),
        .win_highwater(win_highwater), .win_data_valid(win_data_valid));

    // reference model state
    bit m_evq = 1'b1;
    int m_st = 0, m_hc = 0, m_tick = 0, m_wc = 0;
    logic [STAMP_W-1:0] q[$];
    int a_cap = 0, a_drop = 0, a_miss = 0, a_ovf = 0, a_hw = 0;
    bit a_lock = 1, a_last = 0;
    bit e_done = 0, e_valid = 0;
    int e_cap = 0, e_drop = 0, e_miss = 0, e_ovf = 0, e_hw = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic step(input bit ev, input bit rdy, input bit lk,
                        input logic [FINE_W-1:0] fn, input int hold);
        bit rise, fire, miss, drop, store, last;
        int n_cap, n_drop, n_miss, n_ovf, n_hw;
        bit n_lock;
        // compare outputs settled after the previous edge
        check(stamp_valid === (q.size() > 0), "R4 valid", stamp_valid, q.size() > 0);
        if (q.size() > 0)
            check(stamp_data === q[0], "R1 R8 head word", stamp_data, q[0]);
        check(win_done === e_done, "R7 done pulse", win_done, e_done);
        if (e_done) begin
            check(win_captured == CNT_W'(e_cap), "R11 captured", win_captured, e_cap);
            check(win_dropped == CNT_W'(e_drop), "R5 dropped", win_dropped, e_drop);
            check(win_missed == CNT_W'(e_miss), "R3 missed", win_missed, e_miss);
            check(win_overflow_cnt == CNT_W'(e_ovf), "R6 episodes", win_overflow_cnt, e_ovf);
            check(win_highwater == LVL_W'(e_hw), "R9 highwater", win_highwater, e_hw);
            check(win_data_valid === e_valid, "R10 trust", win_data_valid, e_valid);
        end
        // drive
        ev_in = ev; stamp_ready = rdy; ref_locked = lk; fine_code = fn;
        holdoff_ticks = HOLD_W'(hold);
        // model the coming edge
        rise = ev && !m_evq; m_evq = ev;
        fire = 0; miss = 0;
        if (m_st == 0) begin
            if (rise) begin
                fire = 1;
                if (hold != 0) begin m_st = 1; m_hc = hold; end
            end
        end else begin
            miss = rise;
            if (m_hc == 1) m_st = 0;
            m_hc--;
        end
        drop  = fire && (q.size() == DEPTH);
        store = fire && (q.size() != DEPTH);
        if (rdy && q.size() > 0) void'(q.pop_front());
        if (store) q.push_back({m_tick[COARSE_W-1:0], fn});
        m_tick++;
        n_cap = a_cap + int'(store); n_drop = a_drop + int'(drop);
        n_miss = a_miss + int'(miss); n_ovf = a_ovf + int'(drop && !a_last);
        n_hw = imax(a_hw, q.size()); n_lock = a_lock && lk;
        last = (m_wc == WIN_LEN - 1);
        if (last) begin
            e_done = 1; e_cap = n_cap; e_drop = n_drop; e_miss = n_miss;
            e_ovf = n_ovf; e_hw = n_hw; e_valid = n_lock && (n_ovf == 0);
            a_cap = 0; a_drop = 0; a_miss = 0; a_ovf = 0; a_hw = q.size();
            a_lock = 1; a_last = 0; m_wc = 0;
        end else begin
            e_done = 0; a_cap = n_cap; a_drop = n_drop; a_miss = n_miss;
            a_ovf = n_ovf; a_hw = n_hw; a_lock = n_lock; m_wc++;
            if (drop) a_last = 1; else if (store) a_last = 0;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL R7 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R2: reset state
        check(stamp_valid === 1'b0, "R2 valid", stamp_valid, 0);
        check(win_done === 1'b0, "R2 done", win_done, 0);
        check(win_captured == 0 && win_dropped == 0 && win_missed == 0, "R2 counts", win_captured, 0);
        check(win_highwater == 0, "R2 highwater", win_highwater, 0);
        check(win_data_valid === 1'b0, "R2 trust", win_data_valid, 0);
        rst_n = 1'b1;
        // R3: edges every 2 cycles against holdoff 3
        for (int i = 0; i < 80; i++) step(i[0] == 1'b0, 1'b1, 1'b1, FINE_W'(i), 3);
        // R5 R6: stalled consumer, dense edges, no holdoff
        for (int i = 0; i < 40; i++) step(i[0] == 1'b0, 1'b0, 1'b1, FINE_W'(i * 5), 0);
        for (int i = 0; i < 40; i++) step(1'b0, 1'b1, 1'b1, '0, 0);
        // R10: single-cycle lock loss with sparse edges
        for (int i = 0; i < 80; i++) step(i % 9 == 0, 1'b1, i != 20, FINE_W'(i), 1);
        // random traffic with stall bursts
        for (int i = 0; i < 6000; i++) begin
            bit stall = ((i / 250) % 3) == 1;
            step($urandom % 3 == 0, stall ? ($urandom % 8 == 0) : ($urandom % 4 != 0),
                 $urandom % 150 != 0, FINE_W'($urandom), int'($urandom % 5));
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule